// File: doc/BRIEF.md
# Precise Exception Control Unit

This unit decides, every cycle, whether a five-stage in-order pipeline must abandon its current work and enter an exception handler. Two kinds of fault reach it: an arithmetic overflow raised by the instruction in the execute stage, and an unrecognised opcode raised by the instruction in the decode stage. Each fault flag arrives with a valid bit and the program counter of the instruction that raised it. Because the execute-stage instruction is always the older of the two, its overflow wins when both are raised in the same cycle. Taking the oldest fault first is what keeps exceptions precise.

When a fault is taken, the unit raises the flush lines for every pipeline register that holds the faulting instruction or anything younger. It also raises a line that kills the faulting instruction's register write, and it presents a handler address to the fetch stage, which loads that address on the next clock edge. On that same edge it records the return address, which is the faulting PC plus 4, and a one-bit cause code. A parameter selects one of two handler layouts. In the first, every fault goes to a single fixed entry point. In the second, the entry point is picked by the cause.

During the cycle that follows a taken fault, the decode and execute stages hold only bubbles created by the flush. Any fault flag seen in that cycle is therefore stale, and the unit ignores it.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset, `epc` is 0, `cause` is 0, and no flush, suppress or redirect line is high.
- R2: A valid overflow in execute raises `flush_ifid`, `flush_idex`, `flush_exmem`, `wb_suppress` and `redirect_valid` combinationally in the same cycle.
- R3: A valid undefined opcode in decode, with no overflow taken, raises `flush_ifid`, `flush_idex`, `wb_suppress` and `redirect_valid`, and leaves `flush_exmem` low so that the older instruction in execute completes.
- R4: On the clock edge that ends the cycle in which a fault is taken, `epc` loads the faulting instruction's PC plus 4.
- R5: `cause` is one bit wide. The value 0 means undefined opcode and the value 1 means overflow. It is loaded on the same edge as `epc`.
- R6: When an overflow and an undefined opcode are both valid in the same cycle, the overflow is taken. `cause` becomes 1, `epc` becomes `ex_pc` plus 4, and `flush_exmem` is high.
- R7: In fixed mode (`VECTORED`=0), `redirect_pc` is 0x80000180 for either cause.
- R8: In vectored mode (`VECTORED`=1), `redirect_pc` is 0xC0000000 for an undefined opcode and 0xC0000020 for an overflow.
- R9: In any cycle with no taken fault, `epc` and `cause` keep their values.
- R10: A fault flag whose stage valid bit is low is ignored.
- R11: In the cycle right after a taken fault, both fault flags are ignored: no redirect, no flush, and no update of `epc` or `cause`.
- R12: When no fault is taken, all flush lines, `wb_suppress` and `redirect_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_ovf | input | 1 | Execute-stage arithmetic overflow |
| ex_pc | input | PC_W | PC of the execute-stage instruction |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_undef | input | 1 | Decode-stage undefined opcode |
| id_pc | input | PC_W | PC of the decode-stage instruction |
| flush_ifid | output | 1 | Load a bubble into the fetch/decode register |
| flush_idex | output | 1 | Load a bubble into the decode/execute register |
| flush_exmem | output | 1 | Load a bubble into the execute/memory register |
| wb_suppress | output | 1 | Kill the faulting instruction's register write |
| redirect_valid | output | 1 | Fetch must load `redirect_pc` on the next edge |
| redirect_pc | output | PC_W | Handler entry address |
| epc | output | PC_W | Saved return address (faulting PC plus 4) |
| cause | output | 1 | Saved cause: 0 undefined opcode, 1 overflow |

## Verification
The hardest case to reach is a fault flag that stays raised in the cycle directly after a fault is taken. In a real pipeline this cannot happen, because the flush has already turned both stages into bubbles. The bench therefore produces it on purpose: it holds the overflow flag high across two edges and changes the PC in between. It then confirms that the second cycle produces neither a redirect nor an update of `epc`, and that a third cycle with the flag still raised is taken again. Same-cycle faults in both stages are applied to a fixed-mode instance and a vectored-mode instance side by side, which exposes the priority order through the saved cause and through both handler addresses.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic {
    CAUSE_UNDEF = 1'b0,
    CAUSE_OVF   = 1'b1
  } exc_cause_e;
endpackage

// File: rtl/exc_detect.sv
module exc_detect
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            blank,
  input  logic            ex_valid,
  input  logic            ex_ovf,
  input  logic [PC_W-1:0] ex_pc,
  input  logic            id_valid,
  input  logic            id_undef,
  input  logic [PC_W-1:0] id_pc,
  output logic            take,
  output exc_cause_e      take_cause,
  output logic [PC_W-1:0] fault_pc,
  output logic            flush_ifid,
  output logic            flush_idex,
  output logic            flush_exmem,
  output logic            wb_suppress
);
  logic ovf_hit;
  logic undef_hit;

  // The execute-stage instruction is older, so its overflow wins.
  assign ovf_hit   = !blank && ex_valid && ex_ovf;
  assign undef_hit = !blank && id_valid && id_undef && !ovf_hit;

  always_comb begin
    take        = ovf_hit || undef_hit;
    take_cause  = ovf_hit ? CAUSE_OVF : CAUSE_UNDEF;
    fault_pc    = ovf_hit ? ex_pc : id_pc;
    flush_ifid  = take;
    flush_idex  = take;
    flush_exmem = ovf_hit;
    wb_suppress = take;
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter bit              VECTORED   = 1'b0,
  parameter logic [PC_W-1:0] FIXED_ADDR = 32'h8000_0180,
  parameter logic [PC_W-1:0] VEC_BASE   = 32'hC000_0000,
  parameter logic [PC_W-1:0] VEC_STRIDE = 32'h0000_0020
) (
  input  exc_cause_e      cause_in,
  output logic [PC_W-1:0] target
);
  localparam logic [PC_W-1:0] UNDEF_ADDR = VEC_BASE;
  localparam logic [PC_W-1:0] OVF_ADDR   = VEC_BASE + VEC_STRIDE;

  logic [PC_W-1:0] vec_addr;

  always_comb begin
    vec_addr = (cause_in == CAUSE_OVF) ? OVF_ADDR : UNDEF_ADDR;
    target   = VECTORED ? vec_addr : FIXED_ADDR;
  end
endmodule

// File: rtl/exc_regs.sv
module exc_regs
  import exc_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  exc_cause_e      take_cause,
  input  logic [PC_W-1:0] fault_pc,
  output logic [PC_W-1:0] epc_q,
  output exc_cause_e      cause_q,
  output logic            blank_q
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q   <= '0;
      cause_q <= CAUSE_UNDEF;
      blank_q <= 1'b0;
    end else begin
      blank_q <= take;
      if (take) begin
        epc_q   <= fault_pc + STEP;
        cause_q <= take_cause;
      end
    end
  end
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
  import exc_pkg::*;
#(
  parameter int              PC_W          = 32,
  parameter int              PC_STEP       = 4,
  parameter bit              VECTORED      = 1'b0,
  parameter logic [PC_W-1:0] FIXED_HANDLER = 32'h8000_0180,
  parameter logic [PC_W-1:0] VEC_BASE      = 32'hC000_0000,
  parameter logic [PC_W-1:0] VEC_STRIDE    = 32'h0000_0020
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ex_valid,
  input  logic            ex_ovf,
  input  logic [PC_W-1:0] ex_pc,
  input  logic            id_valid,
  input  logic            id_undef,
  input  logic [PC_W-1:0] id_pc,
  output logic            flush_ifid,
  output logic            flush_idex,
  output logic            flush_exmem,
  output logic            wb_suppress,
  output logic            redirect_valid,
  output logic [PC_W-1:0] redirect_pc,
  output logic [PC_W-1:0] epc,
  output logic            cause
);
  logic            take;
  exc_cause_e      take_cause;
  logic [PC_W-1:0] fault_pc;
  logic            blank_q;
  exc_cause_e      cause_q;

  exc_detect #(.PC_W(PC_W)) u_detect (
    .blank      (blank_q || rst),
    .ex_valid   (ex_valid),
    .ex_ovf     (ex_ovf),
    .ex_pc      (ex_pc),
    .id_valid   (id_valid),
    .id_undef   (id_undef),
    .id_pc      (id_pc),
    .take       (take),
    .take_cause (take_cause),
    .fault_pc   (fault_pc),
    .flush_ifid (flush_ifid),
    .flush_idex (flush_idex),
    .flush_exmem(flush_exmem),
    .wb_suppress(wb_suppress)
  );

  exc_vector #(
    .PC_W      (PC_W),
    .VECTORED  (VECTORED),
    .FIXED_ADDR(FIXED_HANDLER),
    .VEC_BASE  (VEC_BASE),
    .VEC_STRIDE(VEC_STRIDE)
  ) u_vector (
    .cause_in(take_cause),
    .target  (redirect_pc)
  );

  exc_regs #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .take_cause(take_cause),
    .fault_pc  (fault_pc),
    .epc_q     (epc),
    .cause_q   (cause_q),
    .blank_q   (blank_q)
  );

  assign redirect_valid = take;
  assign cause          = cause_q;
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            ex_valid,
  input logic            ex_ovf,
  input logic [PC_W-1:0] ex_pc,
  input logic            id_valid,
  input logic            id_undef,
  input logic [PC_W-1:0] id_pc,
  input logic            flush_ifid,
  input logic            flush_idex,
  input logic            flush_exmem,
  input logic            wb_suppress,
  input logic            redirect_valid,
  input logic [PC_W-1:0] epc,
  input logic            cause
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  // R2
  ovf_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && ex_ovf && !$past(redirect_valid)) |->
      (flush_ifid && flush_idex && flush_exmem && wb_suppress && redirect_valid));

  // R3
  undef_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (id_valid && id_undef && !(ex_valid && ex_ovf) && !$past(redirect_valid)) |->
      (flush_ifid && flush_idex && !flush_exmem && redirect_valid));

  // R4
  epc_load_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> (epc == $past((ex_valid && ex_ovf) ? ex_pc : id_pc) + STEP));

  // R6
  cause_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (redirect_valid && ex_valid && ex_ovf) |=> cause);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !redirect_valid |=> ($stable(epc) && $stable(cause)));

  // R11
  blank_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> !redirect_valid);

  // R12
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !redirect_valid |-> !(flush_ifid || flush_idex || flush_exmem || wb_suppress));
endmodule

bind exc_ctrl_unit exc_ctrl_chk #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_chk (.*);

// File: tb/sim_exc_ctrl_unit.sv
module sim_exc_ctrl_unit;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ex_valid = 1'b0, ex_ovf = 1'b0, id_valid = 1'b0, id_undef = 1'b0;
  logic [PC_W-1:0] ex_pc = '0, id_pc = '0;

  logic f_ifid, f_idex, f_exmem, supp, rv;
  logic [PC_W-1:0] rpc, epc;
  logic cause;
  logic v_ifid, v_idex, v_exmem, v_supp, v_rv;
  logic [PC_W-1:0] v_rpc, v_epc;
  logic v_cause;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_ctrl_unit #(.PC_W(PC_W)) u0 (
    .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc),
    .id_valid(id_valid), .id_undef(id_undef), .id_pc(id_pc),
    .flush_ifid(f_ifid), .flush_idex(f_idex), .flush_exmem(f_exmem),
    .wb_suppress(supp), .redirect_valid(rv), .redirect_pc(rpc),
    .epc(epc), .cause(cause)
  );

  exc_ctrl_unit #(.PC_W(PC_W), .VECTORED(1'b1)) u1 (
    .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc),
    .id_valid(id_valid), .id_undef(id_undef), .id_pc(id_pc),
    .flush_ifid(v_ifid), .flush_idex(v_idex), .flush_exmem(v_exmem),
    .wb_suppress(v_supp), .redirect_valid(v_rv), .redirect_pc(v_rpc),
    .epc(v_epc), .cause(v_cause)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic clear_inputs();
    ex_valid = 1'b0; ex_ovf = 1'b0; id_valid = 1'b0; id_undef = 1'b0;
  endtask

  // After a taken fault: clear, then let the blanking cycle pass.
  task automatic settle();
    clear_inputs();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    #1;
    chk_eq("R1 epc", epc, 32'h0);
    chk_eq("R1 cause", {31'b0, cause}, 32'h0);
    chk_eq("R1 lines", {27'b0, f_ifid, f_idex, f_exmem, supp, rv}, 32'h0);
  endtask

  task automatic t_ovf(input logic [31:0] pc);
    @(negedge clk);
    ex_valid = 1'b1; ex_ovf = 1'b1; ex_pc = pc;
    #1;
    chk_eq("R2 flush/suppress/redirect", {27'b0, f_ifid, f_idex, f_exmem, supp, rv}, 32'h1f);
    chk_eq("R7 fixed target ovf", rpc, 32'h8000_0180);
    chk_eq("R8 vectored target ovf", v_rpc, 32'hC000_0020);
    @(posedge clk); #1;
    chk_eq("R4 epc ovf", epc, pc + 32'd4);
    chk_eq("R5 cause ovf", {31'b0, cause}, 32'h1);
    settle();
  endtask

  task automatic t_undef(input logic [31:0] pc);
    @(negedge clk);
    id_valid = 1'b1; id_undef = 1'b1; id_pc = pc;
    ex_valid = 1'b1; ex_ovf = 1'b0; ex_pc = pc - 32'd4;
    #1;
    chk_eq("R3 flush/suppress/redirect", {27'b0, f_ifid, f_idex, f_exmem, supp, rv}, 32'h1b);
    chk_eq("R7 fixed target undef", rpc, 32'h8000_0180);
    chk_eq("R8 vectored target undef", v_rpc, 32'hC000_0000);
    @(posedge clk); #1;
    chk_eq("R4 epc undef", epc, pc + 32'd4);
    chk_eq("R5 cause undef", {31'b0, cause}, 32'h0);
    chk_eq("R8 vectored epc undef", v_epc, pc + 32'd4);
    settle();
  endtask

  task automatic t_both(input logic [31:0] pc_ex, input logic [31:0] pc_id);
    @(negedge clk);
    ex_valid = 1'b1; ex_ovf = 1'b1; ex_pc = pc_ex;
    id_valid = 1'b1; id_undef = 1'b1; id_pc = pc_id;
    #1;
    chk_eq("R6 exmem flushed", {31'b0, f_exmem}, 32'h1);
    chk_eq("R6 vectored target", v_rpc, 32'hC000_0020);
    @(posedge clk); #1;
    chk_eq("R6 epc from execute", epc, pc_ex + 32'd4);
    chk_eq("R6 cause ovf", {31'b0, v_cause}, 32'h1);
    settle();
  endtask

  task automatic t_idle(input logic [31:0] exp_epc, input logic exp_cause);
    @(negedge clk);
    ex_valid = 1'b1; id_valid = 1'b1; ex_pc = 32'h0000_7000; id_pc = 32'h0000_7004;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk_eq("R12 no lines", {27'b0, f_ifid, f_idex, f_exmem, supp, rv}, 32'h0);
      @(negedge clk);
    end
    chk_eq("R9 epc held", epc, exp_epc);
    chk_eq("R9 cause held", {31'b0, cause}, {31'b0, exp_cause});
    clear_inputs();
  endtask

  task automatic t_invalid(input logic [31:0] exp_epc);
    @(negedge clk);
    ex_valid = 1'b0; ex_ovf = 1'b1; ex_pc = 32'h0000_9000;
    id_valid = 1'b0; id_undef = 1'b1; id_pc = 32'h0000_9004;
    #1;
    chk_eq("R10 no redirect", {31'b0, rv}, 32'h0);
    @(posedge clk); #1;
    chk_eq("R10 epc unchanged", epc, exp_epc);
    clear_inputs();
  endtask

  task automatic t_blank(input logic [31:0] pc_a, input logic [31:0] pc_b);
    @(negedge clk);
    ex_valid = 1'b1; ex_ovf = 1'b1; ex_pc = pc_a;
    #1;
    chk_eq("R11 first taken", {31'b0, rv}, 32'h1);
    @(posedge clk); #1;
    ex_pc = pc_b;
    chk_eq("R11 epc first", epc, pc_a + 32'd4);
    @(negedge clk); #1;
    chk_eq("R11 blanked lines", {27'b0, f_ifid, f_idex, f_exmem, supp, rv}, 32'h0);
    @(posedge clk); #1;
    chk_eq("R11 epc not updated", epc, pc_a + 32'd4);
    @(negedge clk); #1;
    chk_eq("R11 taken again", {31'b0, rv}, 32'h1);
    @(posedge clk); #1;
    chk_eq("R11 epc second", epc, pc_b + 32'd4);
    settle();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    t_reset();
    @(posedge clk);
    t_ovf(32'h0000_004C);
    t_undef(32'h0000_0120);
    t_idle(32'h0000_0124, 1'b0);
    t_both(32'h0000_0200, 32'h0000_0204);
    t_invalid(32'h0000_0204);
    t_blank(32'h0000_0300, 32'h0000_0304);
    t_ovf(32'hFFFF_FFFC);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end
endmodule